// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Loader

This block is the master side of a byte-parallel FPGA configuration port. When `start` arrives it drives the program pin of the target device low and waits for the device to pull its init pin low. It then releases the program pin and waits for the init pin to return high. Next it selects the port, writing the write-enable before the chip-select, and lets the port settle. After that it clocks bitstream bytes taken from a valid/ready stream onto the device, one byte per configuration clock.

Three conditions are tested before every byte. A low init pin means a configuration (CRC) error, and the load is aborted. A high done pin means the device has finished early, so the block stops sending and goes on to verification. With busy checking enabled, a busy pin that stays high too long also aborts the load. After the last byte the port is deselected, chip-select first. The load succeeds if done and init are both high within the completion window.

Every phase has its own watchdog, counted in clock cycles. The result is reported as a one-cycle `load_done` pulse. A pass flag and a three-bit cause code come with it and stay held until the next load begins. The device status inputs pass through two-flop synchronizers.

Top module: `cfg_loader`

## Requirements
- R1: After reset and whenever idle, `prog_b`, `cs_b`, `write_b` and `cclk` are high, `cfg_d_oe` is low, `s_ready` is low and `load_done` is low.
- R2: On `start` in idle, `prog_b` goes low. It stays low for at least PROG_MIN_CYC cycles and until the synchronized init pin has been seen low. `cs_b` is high throughout.
- R3: If init does not read low within INIT_TO_CYC cycles of `prog_b` falling, the load ends with pass 0 and cause 1.
- R4: If init does not read high within INIT_TO_CYC cycles of `prog_b` rising, the load ends with pass 0 and cause 2.
- R5: `write_b` falls at least one cycle before `cs_b`. At least SETTLE_CYC cycles pass between `cs_b` falling and the first rising `cclk`.
- R6: Each accepted stream byte is placed on `cfg_d_out` while `cfg_d_oe` is high. `cclk` is then driven low for CCLK_HALF cycles and high again. Bytes reach the device on the rising `cclk` in stream order, and the data stays stable while `cclk` is low.
- R7: If init reads low before a byte, the load aborts with pass 0 and cause 3. On the cycle after the report, `cs_b` and `write_b` are high and `cfg_d_oe` is low.
- R8: If done reads high before a byte, no further bytes are clocked. The block goes on to verification, and the load passes when init is also high.
- R9: With CHECK_BUSY set, the block waits after each byte until busy reads low. If busy stays high for BUSY_TO_CYC cycles, the load ends with pass 0 and cause 4.
- R10: After the final byte (the one marked `s_last`), `cs_b` rises while `write_b` is still low, and `write_b` rises one cycle later.
- R11: If done and init both read high within DONE_TO_CYC cycles after deselect, the result is pass 1 with cause 0. Otherwise it is pass 0 with cause 5.
- R12: `load_done` is high for exactly one cycle. `load_pass` and `load_cause` hold their value until the next accepted `start`. A `start` during a load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (accepted only in idle) |
| s_data | input | 8 | Bitstream byte |
| s_valid | input | 1 | Byte valid |
| s_last | input | 1 | Marks the final byte |
| s_ready | output | 1 | Byte taken on this cycle when valid |
| prog_b | output | 1 | Device program pin, active low |
| cs_b | output | 1 | Port chip-select, active low |
| write_b | output | 1 | Port write-enable, active low |
| cclk | output | 1 | Configuration clock |
| cfg_d_out | output | 8 | Data bus value |
| cfg_d_oe | output | 1 | Data bus output enable (low means tri-stated) |
| init_b_in | input | 1 | Device init pin (asynchronous) |
| done_in | input | 1 | Device done pin (asynchronous) |
| busy_in | input | 1 | Device busy pin (asynchronous) |
| load_done | output | 1 | One-cycle end-of-load pulse |
| load_pass | output | 1 | Result of the last load |
| load_cause | output | 3 | 0 none, 1 init not low, 2 init not high, 3 init dropped in data, 4 busy timeout, 5 completion timeout |

## Verification
All pin outputs are registered on the same edge as the state, so `load_done`, `load_pass` and `load_cause` appear together. They show on the first cycle of the report state. Device responses pass through two synchronizer flops, so a change on init, done or busy takes effect two to three cycles later. The busy wait never samples before that latency has passed. The bench therefore never predicts exact completion cycles. It waits for `load_done` with a bounded loop and samples at the falling edge of that cycle. The next falling edge is used for the one-cycle pulse and the released pins. Timing windows (program pulse width, settle gap, clock-low width, deselect order) are measured by a device model that counts falling edges and compares the counts against lower bounds.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAIT_INIT,
        ST_WR_ON,
        ST_SETTLE,
        ST_CHECK,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_BUSY,
        ST_CS_OFF,
        ST_WR_OFF,
        ST_VERIFY,
        ST_REPORT
    } ld_state_e;

    typedef enum logic [2:0] {
        CAUSE_NONE      = 3'd0,
        CAUSE_NO_INIT_L = 3'd1,
        CAUSE_NO_INIT_H = 3'd2,
        CAUSE_CRC       = 3'd3,
        CAUSE_BUSY      = 3'd4,
        CAUSE_COMPLETE  = 3'd5
    } fail_cause_e;

    typedef struct packed {
        logic prog_b;
        logic cs_b;
        logic write_b;
        logic cclk;
        logic d_oe;
    } pins_t;

    function automatic pins_t pins_for(ld_state_e s);
        pins_t p;
        p = '{prog_b: 1'b1, cs_b: 1'b1, write_b: 1'b1, cclk: 1'b1, d_oe: 1'b0};
        case (s)
            ST_PROG:   p.prog_b = 1'b0;
            ST_WR_ON:  p.write_b = 1'b0;
            ST_SETTLE, ST_CHECK, ST_CLK_HI, ST_BUSY: begin
                p.write_b = 1'b0;
                p.cs_b    = 1'b0;
                p.d_oe    = 1'b1;
            end
            ST_CLK_LO: begin
                p.write_b = 1'b0;
                p.cs_b    = 1'b0;
                p.d_oe    = 1'b1;
                p.cclk    = 1'b0;
            end
            ST_CS_OFF: p.write_b = 1'b0;
            default:   ;
        endcase
        return p;
    endfunction

    function automatic int unsigned max_of(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clear)    count <= '0;
        else if (count != TOP) count <= count + 1'b1;
    end

    // R3
    timer_saturate_chk: assert property (@(posedge clk) disable iff (rst)
        (count == TOP && !clear) |=> (count == TOP));
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int unsigned PROG_MIN_CYC = 30,
    parameter int unsigned INIT_TO_CYC  = 50_000_000,
    parameter int unsigned BUSY_TO_CYC  = 500_000,
    parameter int unsigned DONE_TO_CYC  = 20_000_000,
    parameter int unsigned SETTLE_CYC   = 1_000_000,
    parameter int unsigned CCLK_HALF    = 2,
    parameter bit          CHECK_BUSY   = 1'b1,
    parameter int          SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] s_data,
    input  logic       s_valid,
    input  logic       s_last,
    output logic       s_ready,
    output logic       prog_b,
    output logic       cs_b,
    output logic       write_b,
    output logic       cclk,
    output logic [7:0] cfg_d_out,
    output logic       cfg_d_oe,
    input  logic       init_b_in,
    input  logic       done_in,
    input  logic       busy_in,
    output logic       load_done,
    output logic       load_pass,
    output logic [2:0] load_cause
);
    localparam int unsigned MAXV = max_of(max_of(max_of(INIT_TO_CYC, BUSY_TO_CYC),
                                                 max_of(DONE_TO_CYC, SETTLE_CYC)),
                                          max_of(PROG_MIN_CYC, CCLK_HALF));
    localparam int CNT_W = $clog2(MAXV + 1);
    localparam logic [CNT_W-1:0] PROG_LIM   = CNT_W'(PROG_MIN_CYC - 1);
    localparam logic [CNT_W-1:0] INIT_LIM   = CNT_W'(INIT_TO_CYC - 1);
    localparam logic [CNT_W-1:0] BUSY_LIM   = CNT_W'(BUSY_TO_CYC - 1);
    localparam logic [CNT_W-1:0] DONE_LIM   = CNT_W'(DONE_TO_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LIM = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] HALF_LIM   = CNT_W'(CCLK_HALF - 1);
    localparam logic [CNT_W-1:0] GUARD_LIM  = CNT_W'(SYNC_STAGES);

    ld_state_e   state_q, state_d;
    fail_cause_e cause_d;
    pins_t       pins_q;
    logic [CNT_W-1:0] cnt;
    logic [2:0]  sync_out;
    logic        init_s, done_s, busy_s;
    logic [7:0]  data_q;
    logic        last_q;
    logic        take;
    logic        pass_q;
    logic [2:0]  cause_q;

    cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({init_b_in, done_in, busy_in}),
        .dout (sync_out)
    );
    assign {init_s, done_s, busy_s} = sync_out;

    cfg_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (state_d != state_q),
        .count (cnt)
    );

    assign s_ready = (state_q == ST_CHECK) && init_s && !done_s;
    assign take    = s_ready && s_valid;

    always_comb begin
        state_d = state_q;
        cause_d = CAUSE_NONE;
        case (state_q)
            ST_IDLE:      if (start) state_d = ST_PROG;
            ST_PROG: begin
                if (cnt >= PROG_LIM && !init_s) state_d = ST_WAIT_INIT;
                else if (cnt >= INIT_LIM) begin
                    state_d = ST_REPORT;
                    cause_d = CAUSE_NO_INIT_L;
                end
            end
            ST_WAIT_INIT: begin
                if (init_s) state_d = ST_WR_ON;
                else if (cnt >= INIT_LIM) begin
                    state_d = ST_REPORT;
                    cause_d = CAUSE_NO_INIT_H;
                end
            end
            ST_WR_ON:     state_d = ST_SETTLE;
            ST_SETTLE:    if (cnt >= SETTLE_LIM) state_d = ST_CHECK;
            ST_CHECK: begin
                if (!init_s) begin
                    state_d = ST_REPORT;
                    cause_d = CAUSE_CRC;
                end else if (done_s) state_d = ST_CS_OFF;
                else if (s_valid)   state_d = ST_CLK_LO;
            end
            ST_CLK_LO:    if (cnt >= HALF_LIM) state_d = ST_CLK_HI;
            ST_CLK_HI: begin
                if (cnt >= HALF_LIM) begin
                    if (CHECK_BUSY) state_d = ST_BUSY;
                    else            state_d = last_q ? ST_CS_OFF : ST_CHECK;
                end
            end
            ST_BUSY: begin
                if (cnt >= GUARD_LIM && !busy_s) state_d = last_q ? ST_CS_OFF : ST_CHECK;
                else if (cnt >= BUSY_LIM) begin
                    state_d = ST_REPORT;
                    cause_d = CAUSE_BUSY;
                end
            end
            ST_CS_OFF:    state_d = ST_WR_OFF;
            ST_WR_OFF:    state_d = ST_VERIFY;
            ST_VERIFY: begin
                if (done_s && init_s) state_d = ST_REPORT;
                else if (cnt >= DONE_LIM) begin
                    state_d = ST_REPORT;
                    cause_d = CAUSE_COMPLETE;
                end
            end
            ST_REPORT:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pins_q  <= pins_for(ST_IDLE);
            data_q  <= '0;
            last_q  <= 1'b0;
            pass_q  <= 1'b0;
            cause_q <= '0;
        end else begin
            state_q <= state_d;
            pins_q  <= pins_for(state_d);
            if (take) begin
                data_q <= s_data;
                last_q <= s_last;
            end
            if (state_q == ST_IDLE && start) begin
                pass_q  <= 1'b0;
                cause_q <= '0;
            end else if (state_d == ST_REPORT && state_q != ST_REPORT) begin
                pass_q  <= (cause_d == CAUSE_NONE);
                cause_q <= cause_d;
            end
        end
    end

    assign prog_b     = pins_q.prog_b;
    assign cs_b       = pins_q.cs_b;
    assign write_b    = pins_q.write_b;
    assign cclk       = pins_q.cclk;
    assign cfg_d_oe   = pins_q.d_oe;
    assign cfg_d_out  = data_q;
    assign load_done  = (state_q == ST_REPORT);
    assign load_pass  = pass_q;
    assign load_cause = cause_q;

    // R5
    cs_needs_wr_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_b |-> !write_b);
    // R2
    prog_isolates_chk: assert property (@(posedge clk) disable iff (rst)
        !prog_b |-> (cs_b && write_b));
    // R6
    cclk_framed_chk: assert property (@(posedge clk) disable iff (rst)
        !cclk |-> (!cs_b && cfg_d_oe));
    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cclk && $past(!cclk)) |-> $stable(cfg_d_out));
    // R7
    bus_released_chk: assert property (@(posedge clk) disable iff (rst)
        cs_b |-> !cfg_d_oe);
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        load_done |=> !load_done);
    // R11
    pass_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (load_done && load_pass) |-> (load_cause == 3'd0));
endmodule

// File: tb/sim_cfg_loader.sv
module sim_cfg_loader;
    localparam int CLK_PERIOD = 10;
    localparam int PROG_MIN = 6;
    localparam int INIT_TO  = 50;
    localparam int BUSY_TO  = 40;
    localparam int DONE_TO  = 60;
    localparam int SETTLE   = 8;
    localparam int HALF     = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [7:0] s_data;
    logic s_valid, s_last, s_ready;
    logic prog_b, cs_b, write_b, cclk, cfg_d_oe, load_done, load_pass;
    logic [7:0] cfg_d_out;
    logic [2:0] load_cause;
    logic init_r = 1'b1, done_r = 1'b0, busy_r = 1'b0;

    cfg_loader #(
        .PROG_MIN_CYC(PROG_MIN), .INIT_TO_CYC(INIT_TO), .BUSY_TO_CYC(BUSY_TO),
        .DONE_TO_CYC(DONE_TO), .SETTLE_CYC(SETTLE), .CCLK_HALF(HALF),
        .CHECK_BUSY(1'b1), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .s_data(s_data), .s_valid(s_valid),
        .s_last(s_last), .s_ready(s_ready), .prog_b(prog_b), .cs_b(cs_b),
        .write_b(write_b), .cclk(cclk), .cfg_d_out(cfg_d_out), .cfg_d_oe(cfg_d_oe),
        .init_b_in(init_r), .done_in(done_r), .busy_in(busy_r),
        .load_done(load_done), .load_pass(load_pass), .load_cause(load_cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0;

    // model settings, written only by the stimulus tasks
    int m_lo = 3, m_hi = 10, m_done_at = 0, m_crc_at = 0, m_busy = 0, m_len = 0, m_id = 0;

    // model state, written only by the model process
    int cyc = 0, prog_lo = 0, pulses = 0, rel = 0, nbytes = 0, ncap = 0;
    int cs_fall_t = 0, first_rise_t = 0, gap_first = 0, lo_run = 0, lo_bad = 0;
    int order_bad = 0, end_bad = 0, busy_left = 0, ptr = 0, seen_id = 0;
    bit crc_flag = 0, pend = 0;
    logic prog_p = 1, cs_p = 1, cclk_p = 1;
    logic [7:0] cap [256];

    function automatic logic [7:0] pat(int id, int i);
        return 8'((id * 37 + i * 11 + 5) & 255);
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (!prog_b) begin
            if (prog_p) begin
                pulses++; prog_lo = 0; nbytes = 0; crc_flag = 0; busy_left = 0;
            end
            prog_lo++;
            done_r = 1'b0;
            rel = 0;
            if (m_lo >= 0 && prog_lo >= m_lo) init_r = 1'b0;
        end else if (!init_r && !crc_flag) begin
            rel++;
            if (m_hi >= 0 && rel >= m_hi) init_r = 1'b1;
        end
        if (busy_left > 0) busy_left--;
        if (!cclk) lo_run++;
        if (cclk && !cclk_p && !cs_b && !write_b && cfg_d_oe) begin
            if (lo_run < HALF) lo_bad++;
            cap[ncap[7:0]] = cfg_d_out;
            ncap++;
            nbytes++;
            if (nbytes == 1) begin
                first_rise_t = cyc;
                gap_first = cyc - cs_fall_t;
            end
            if (m_busy > 0) busy_left = m_busy;
            if (m_crc_at == nbytes) begin init_r = 1'b0; crc_flag = 1; end
            if (m_done_at == nbytes) done_r = 1'b1;
        end
        if (cclk) lo_run = 0;
        busy_r = (busy_left > 0);
        if (!cs_b && cs_p) begin cs_fall_t = cyc; if (write_b) order_bad++; end
        if (cs_b && !cs_p && write_b) end_bad++;
        prog_p = prog_b; cs_p = cs_b; cclk_p = cclk;
        // byte stream source
        if (seen_id != m_id) begin seen_id = m_id; ptr = 0; pend = 0; end
        if (pend) ptr++;
        s_valid = (ptr < m_len);
        s_data  = pat(m_id, ptr);
        s_last  = (ptr == m_len - 1);
        pend    = s_valid && s_ready;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    int r_pass, r_cause, r_got, r_base, r_pulse0, r_ob, r_eb, r_lb;

    task automatic do_load(input int lo, input int hi, input int done_at,
                           input int crc_at, input int busy, input int len);
        int n;
        m_lo = lo; m_hi = hi; m_done_at = done_at; m_crc_at = crc_at;
        m_busy = busy; m_len = len; m_id = m_id + 1;
        @(negedge clk);
        r_base = ncap; r_pulse0 = pulses; r_ob = order_bad; r_eb = end_bad; r_lb = lo_bad;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!load_done && n < 3000) begin @(negedge clk); n++; end
        chk(load_done == 1'b1, "R12 load_done seen", int'(load_done), 1);
        r_pass = int'(load_pass); r_cause = int'(load_cause); r_got = ncap - r_base;
        @(negedge clk);
        chk(load_done == 1'b0, "R12 pulse one cycle", int'(load_done), 0);
        chk(cs_b && write_b && !cfg_d_oe && prog_b, "R1 pins released after load",
            int'({prog_b, cs_b, write_b, cfg_d_oe}), 4'b1110);
    endtask

    task automatic t_reset;
        chk(prog_b && cs_b && write_b && cclk, "R1 control pins high", int'({prog_b, cs_b, write_b, cclk}), 15);
        chk(!cfg_d_oe && !s_ready && !load_done, "R1 bus off, no ready, no done",
            int'({cfg_d_oe, s_ready, load_done}), 0);
    endtask

    task automatic t_normal;
        bit same = 1;
        do_load(3, 10, 8, 0, 0, 8);
        chk(r_pass == 1 && r_cause == 0, "R11 pass with cause 0", r_cause, 0);
        chk(r_got == 8, "R6 byte count", r_got, 8);
        for (int i = 0; i < 8; i++) if (cap[8'(r_base + i)] != pat(m_id, i)) same = 0;
        chk(same, "R6 bytes in stream order", int'(same), 1);
        chk(prog_lo >= PROG_MIN, "R2 program pulse width", prog_lo, PROG_MIN);
        chk(pulses - r_pulse0 == 1, "R2 one program pulse", pulses - r_pulse0, 1);
        chk(order_bad == r_ob, "R5 write_b before cs_b", order_bad - r_ob, 0);
        chk(gap_first >= SETTLE, "R5 settle gap", gap_first, SETTLE);
        chk(end_bad == r_eb, "R10 cs_b rises before write_b", end_bad - r_eb, 0);
        chk(lo_bad == r_lb, "R6 cclk low width", lo_bad - r_lb, 0);
    endtask

    task automatic t_slow_init;
        do_load(20, 5, 4, 0, 0, 4);
        chk(prog_lo >= 20, "R2 program held until init low", prog_lo, 20);
        chk(r_pass == 1, "R2 slow init load passes", r_pass, 1);
    endtask

    task automatic t_no_init_low;
        do_load(-1, 5, 4, 0, 0, 4);
        chk(r_pass == 0 && r_cause == 1, "R3 init never low", r_cause, 1);
        chk(r_got == 0, "R3 no bytes sent", r_got, 0);
    endtask

    task automatic t_no_release;
        do_load(3, -1, 4, 0, 0, 4);
        chk(r_pass == 0 && r_cause == 2, "R4 init never released", r_cause, 2);
        chk(r_got == 0, "R4 no bytes sent", r_got, 0);
    endtask

    task automatic t_crc;
        do_load(3, 6, 0, 4, 0, 8);
        chk(r_pass == 0 && r_cause == 3, "R7 init drop aborts", r_cause, 3);
        chk(r_got == 4, "R7 bytes before abort", r_got, 4);
        repeat (10) @(negedge clk);
        chk(load_cause == 3'd3 && !load_pass, "R12 result held while idle", int'(load_cause), 3);
    endtask

    task automatic t_done_early;
        do_load(3, 6, 3, 0, 0, 8);
        chk(r_pass == 1 && r_cause == 0, "R8 early done passes", r_cause, 0);
        chk(r_got == 3, "R8 stops after done", r_got, 3);
    endtask

    task automatic t_busy_ok;
        do_load(3, 6, 4, 0, 10, 4);
        chk(r_pass == 1 && r_got == 4, "R9 short busy tolerated", r_got, 4);
    endtask

    task automatic t_busy_to;
        do_load(3, 6, 0, 0, 100, 4);
        chk(r_pass == 0 && r_cause == 4, "R9 busy timeout", r_cause, 4);
        chk(r_got == 1, "R9 held after first byte", r_got, 1);
    endtask

    task automatic t_complete_to;
        do_load(3, 6, 0, 0, 0, 5);
        chk(r_pass == 0 && r_cause == 5, "R11 completion timeout", r_cause, 5);
        chk(r_got == 5, "R11 all bytes sent", r_got, 5);
    endtask

    task automatic t_start_ignored;
        int n, p0, dones;
        m_lo = 3; m_hi = 6; m_done_at = 6; m_crc_at = 0; m_busy = 0; m_len = 6; m_id = m_id + 1;
        @(negedge clk);
        p0 = pulses; dones = 0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (25) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        n = 0;
        while (n < 400) begin
            @(negedge clk);
            if (load_done) dones++;
            n++;
        end
        chk(pulses - p0 == 1, "R12 start ignored during load", pulses - p0, 1);
        chk(dones == 1, "R12 single report", dones, 1);
        chk(load_pass == 1'b1, "R12 ignored start keeps pass", int'(load_pass), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_normal();
        t_slow_init();
        t_no_init_low();
        t_no_release();
        t_crc();
        t_done_early();
        t_busy_ok();
        t_busy_to();
        t_complete_to();
        t_start_ignored();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule